// File: doc/BRIEF.md
# Register-Resident Page Translator

This block turns a 16-bit virtual address into a 22-bit physical address in the same cycle the request arrives. The upper three address bits pick one of eight 8 KiB pages, and the lower thirteen bits pass through unchanged as the offset within the page. Each request also carries a space bit that marks it as an instruction fetch or a data reference. Instruction fetches and data references each have their own bank of eight entries, so each space can reach a full 64 KiB of its own.

All sixteen entries live in on-chip flip-flops. Each entry holds a valid flag and a 9-bit frame number. The lookup is purely combinational from these registers. A hit drives the frame number concatenated with the offset and raises a valid strobe. A miss on an invalid entry raises a fault instead.

Software loads entries one at a time through a write port. On a process switch it can drop every mapping at once with a bulk-invalidate input and then reload the new process's entries.

Top module: `regPageXlate`

## Requirements
- R1: The page index is `reqVaddr[15:13]` and the offset is `reqVaddr[12:0]`. On a hit, `xlPaddr` equals `{frame[8:0], reqVaddr[12:0]}` (22 bits).
- R2: `reqIsInstr` = 1 selects the instruction bank and `reqIsInstr` = 0 selects the data bank. The same page index in the two banks maps independently.
- R3: Translation is combinational: `xlValid`, `xlFault` and `xlPaddr` reflect the request in the same cycle, with no clock edge in between.
- R4: A request (`reqValid` = 1) that hits an entry whose valid flag is clear gives `xlFault` = 1, `xlValid` = 0 and `xlPaddr` = 0.
- R5: With `reqValid` = 0, `xlValid` = 0, `xlFault` = 0 and `xlPaddr` = 0.
- R6: A write (`wrEn` = 1) stores `wrValid` and `wrFrame` into the entry at bank `wrSpace` (1 = instruction, 0 = data) and page `wrPage`. A lookup in the same cycle as the write still sees the old contents. Lookups from the next cycle on see the new contents.
- R7: `invalAll` = 1 for one cycle clears the valid flag of all sixteen entries, effective from the next cycle's lookup.
- R8: When `invalAll` and a write occur in the same cycle, the written entry takes the written contents and every other entry is cleared.
- R9: After reset (`rstN` low), every entry in both banks is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request present |
| reqIsInstr | input | 1 | 1 = instruction fetch, 0 = data reference |
| reqVaddr | input | 16 | Virtual address |
| wrEn | input | 1 | Entry write strobe |
| wrSpace | input | 1 | Bank to write: 1 = instruction, 0 = data |
| wrPage | input | 3 | Page index of the entry to write |
| wrValid | input | 1 | Valid flag to store |
| wrFrame | input | 9 | Frame number to store |
| invalAll | input | 1 | Clear every valid flag |
| xlValid | output | 1 | Translated address valid |
| xlFault | output | 1 | Request hit an invalid entry |
| xlPaddr | output | 22 | Physical address, zero unless `xlValid` |

## Verification
Two things can fall in the same cycle. A bulk invalidate can coincide with a single-entry write, and an entry write can coincide with a lookup of that same entry. The bench provokes the first by filling both banks, then raising `invalAll` together with a write to one entry. It then checks that only that entry still translates and that every other entry faults. It provokes the second by presenting a lookup in the cycle of a write to the same entry. It checks that the old contents answer that cycle and the new contents answer the next.

// File: rtl/pgXlatePkg.sv
package pgXlatePkg;
  localparam int VA_W      = 16;
  localparam int PAGE_W    = 3;
  localparam int FRAME_W   = 9;
  localparam int SPACE_W   = 1;
  localparam int OFF_W     = VA_W - PAGE_W;
  localparam int IDX_W     = SPACE_W + PAGE_W;
  localparam int NUM_ENT   = 1 << IDX_W;
  localparam int PA_W      = FRAME_W + OFF_W;

  // strobes from control to datapath
  typedef struct packed {
    logic             clearAll;
    logic             loadEn;
    logic [IDX_W-1:0] loadIdx;
  } ctrlStrobesT;
endpackage

// File: rtl/pgXlateCtrl.sv
module pgXlateCtrl
  import pgXlatePkg::*;
#(
  parameter int PG_W = PAGE_W,
  parameter int SP_W = SPACE_W
) (
  input  logic              wrEn,
  input  logic [SP_W-1:0]   wrSpace,
  input  logic [PG_W-1:0]   wrPage,
  input  logic              invalAll,
  input  logic              reqValid,
  input  logic              selValid,
  output ctrlStrobesT       strobes,
  output logic              grant,
  output logic              fault
);
  // entry index: space bit above page bits
  always_comb begin
    strobes.clearAll = invalAll;
    strobes.loadEn   = wrEn;
    strobes.loadIdx  = {wrSpace, wrPage};
  end

  always_comb begin
    grant = reqValid &  selValid;
    fault = reqValid & ~selValid;
  end
endmodule

// File: rtl/pgXlateDatapath.sv
module pgXlateDatapath
  import pgXlatePkg::*;
#(
  parameter int VW = VA_W,
  parameter int PG_W = PAGE_W,
  parameter int FR_W = FRAME_W,
  parameter int SP_W = SPACE_W,
  localparam int OW = VW - PG_W,
  localparam int IW = SP_W + PG_W,
  localparam int NE = 1 << IW
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobesT       strobes,
  input  logic              wrValid,
  input  logic [FR_W-1:0]   wrFrame,
  input  logic [SP_W-1:0]   reqSpace,
  input  logic [VW-1:0]     reqVaddr,
  input  logic              grant,
  output logic              selValid,
  output logic [FR_W+OW-1:0] paddr
);
  logic [NE-1:0]   entValid;
  logic [FR_W-1:0] entFrame [NE];
  logic [IW-1:0]   lookIdx;

  for (genvar e = 0; e < NE; e++) begin : g_entry
    logic hitWr;
    assign hitWr = strobes.loadEn && (strobes.loadIdx == IW'(e));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        entValid[e] <= 1'b0;
        entFrame[e] <= '0;
      end else if (hitWr) begin
        // a write beats a bulk clear in the same cycle
        entValid[e] <= wrValid;
        entFrame[e] <= wrFrame;
      end else if (strobes.clearAll) begin
        entValid[e] <= 1'b0;
      end
    end
  end

  assign lookIdx  = {reqSpace, reqVaddr[VW-1 -: PG_W]};
  assign selValid = entValid[lookIdx];

  always_comb begin
    if (grant) paddr = {entFrame[lookIdx], reqVaddr[OW-1:0]};
    else       paddr = '0;
  end
endmodule

// File: rtl/regPageXlate.sv
module regPageXlate
  import pgXlatePkg::*;
#(
  parameter int VW = VA_W,
  parameter int PG_W = PAGE_W,
  parameter int FR_W = FRAME_W,
  localparam int OW = VW - PG_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqIsInstr,
  input  logic [VW-1:0]     reqVaddr,
  input  logic              wrEn,
  input  logic              wrSpace,
  input  logic [PG_W-1:0]   wrPage,
  input  logic              wrValid,
  input  logic [FR_W-1:0]   wrFrame,
  input  logic              invalAll,
  output logic              xlValid,
  output logic              xlFault,
  output logic [FR_W+OW-1:0] xlPaddr
);
  ctrlStrobesT strobes;
  logic        selValid;

  pgXlateCtrl #(.PG_W(PG_W), .SP_W(1)) ctrl_i (
    .wrEn     (wrEn),
    .wrSpace  (wrSpace),
    .wrPage   (wrPage),
    .invalAll (invalAll),
    .reqValid (reqValid),
    .selValid (selValid),
    .strobes  (strobes),
    .grant    (xlValid),
    .fault    (xlFault)
  );

  pgXlateDatapath #(.VW(VW), .PG_W(PG_W), .FR_W(FR_W), .SP_W(1)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .wrValid  (wrValid),
    .wrFrame  (wrFrame),
    .reqSpace (reqIsInstr),
    .reqVaddr (reqVaddr),
    .grant    (xlValid),
    .selValid (selValid),
    .paddr    (xlPaddr)
  );
endmodule

// File: rtl/regPageXlateChk.sv
module regPageXlateChk
  import pgXlatePkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               reqValid,
  input logic               reqIsInstr,
  input logic [VA_W-1:0]    reqVaddr,
  input logic               wrEn,
  input logic               wrSpace,
  input logic [PAGE_W-1:0]  wrPage,
  input logic               wrValid,
  input logic [FRAME_W-1:0] wrFrame,
  input logic               invalAll,
  input logic               xlValid,
  input logic               xlFault,
  input logic [PA_W-1:0]    xlPaddr
);
  logic [IDX_W-1:0] reqIdx;
  assign reqIdx = {reqIsInstr, reqVaddr[VA_W-1 -: PAGE_W]};

  // R1: offset passes through on a hit
  p_offset_pass_r1: assert property (@(posedge clk) disable iff (!rstN)
    xlValid |-> xlPaddr[OFF_W-1:0] == reqVaddr[OFF_W-1:0]);

  // R4: fault and valid never together, faulting address is zero
  p_fault_excl_r4: assert property (@(posedge clk) disable iff (!rstN)
    xlFault |-> (!xlValid && xlPaddr == '0));

  // R5: idle request gives quiet outputs
  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> (!xlValid && !xlFault && xlPaddr == '0));

  // R6: a valid write is visible on the next cycle's lookup of that entry
  p_write_visible_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrValid) |=>
      (!(reqValid && reqIdx == {$past(wrSpace), $past(wrPage)}) ||
       (xlValid && xlPaddr[PA_W-1 -: FRAME_W] == $past(wrFrame))));

  // R7: after a bulk clear without a write nothing translates
  p_clear_all_r7: assert property (@(posedge clk) disable iff (!rstN)
    (invalAll && !wrEn) |=> !xlValid);

  // R8: a written-invalid entry faults next cycle, even alongside a bulk clear
  p_write_invalid_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrValid) |=>
      (!(reqValid && reqIdx == {$past(wrSpace), $past(wrPage)}) || xlFault));
endmodule

bind regPageXlate regPageXlateChk chk_i (.*);

// File: tb/regPageXlate_tb.sv
module regPageXlate_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqIsInstr = 1'b0;
  logic [15:0] reqVaddr = '0;
  logic        wrEn = 1'b0, wrSpace = 1'b0, wrValid = 1'b0, invalAll = 1'b0;
  logic [2:0]  wrPage = '0;
  logic [8:0]  wrFrame = '0;
  logic        xlValid, xlFault;
  logic [21:0] xlPaddr;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  regPageXlate dut_i (.*);

  function automatic logic [8:0] frameOf(int idx);
    return 9'((idx * 37 + 11) & 9'h1FF);
  endfunction

  task automatic checkVal(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // present a request and check the combinational answer (R3)
  task automatic lookup(string tag, logic instr, logic [2:0] page,
                        logic [12:0] off, bit expOk, logic [8:0] expFrame);
    reqValid = 1'b1; reqIsInstr = instr; reqVaddr = {page, off};
    #1;
    checkVal({tag, " valid"}, 32'(xlValid), 32'(expOk));
    checkVal({tag, " fault"}, 32'(xlFault), 32'(!expOk));
    checkVal({tag, " paddr"}, 32'(xlPaddr), expOk ? 32'({expFrame, off}) : 32'h0);
  endtask

  task automatic doWrite(logic sp, logic [2:0] pg, logic v, logic [8:0] fr, logic clr);
    @(negedge clk);
    wrEn = 1'b1; wrSpace = sp; wrPage = pg; wrValid = v; wrFrame = fr; invalAll = clr;
    @(negedge clk);
    wrEn = 1'b0; invalAll = 1'b0;
  endtask

  task automatic fillAll();
    for (int i = 0; i < 16; i++) doWrite(i[3], i[2:0], 1'b1, frameOf(i), 1'b0);
  endtask

  task automatic testReset();
    for (int i = 0; i < 16; i++) lookup("R9 reset entry", i[3], i[2:0], 13'h0AB, 1'b0, 9'h0);
  endtask

  task automatic testIdle();
    reqValid = 1'b0; reqVaddr = 16'hFFFF; #1;
    checkVal("R5 idle valid", 32'(xlValid), 0);
    checkVal("R5 idle fault", 32'(xlFault), 0);
    checkVal("R5 idle paddr", 32'(xlPaddr), 0);
  endtask

  task automatic testBanks();
    doWrite(1'b0, 3'd2, 1'b1, 9'h1A5, 1'b0);
    doWrite(1'b1, 3'd2, 1'b1, 9'h033, 1'b0);
    lookup("R1 R2 data page2 off0", 1'b0, 3'd2, 13'h0000, 1'b1, 9'h1A5);
    lookup("R1 R2 data page2 offmax", 1'b0, 3'd2, 13'h1FFF, 1'b1, 9'h1A5);
    lookup("R2 instr page2", 1'b1, 3'd2, 13'h0555, 1'b1, 9'h033);
    lookup("R2 instr page3 still invalid", 1'b1, 3'd3, 13'h0001, 1'b0, 9'h0);
  endtask

  task automatic testWriteTiming();
    @(negedge clk);
    wrEn = 1'b1; wrSpace = 1'b0; wrPage = 3'd5; wrValid = 1'b1; wrFrame = 9'h0F0;
    lookup("R6 same-cycle old", 1'b0, 3'd5, 13'h0123, 1'b0, 9'h0);
    @(negedge clk);
    wrEn = 1'b0;
    lookup("R6 next-cycle new", 1'b0, 3'd5, 13'h0123, 1'b1, 9'h0F0);
    doWrite(1'b0, 3'd5, 1'b0, 9'h0F0, 1'b0);
    lookup("R4 R6 written invalid", 1'b0, 3'd5, 13'h0123, 1'b0, 9'h0);
  endtask

  task automatic testFull();
    fillAll();
    for (int i = 0; i < 16; i++)
      lookup("R1 R2 full table", i[3], i[2:0], 13'(i * 401), 1'b1, frameOf(i));
  endtask

  task automatic testInvalAll();
    doWrite(1'b0, 3'd0, 1'b0, 9'h0, 1'b1);
    for (int i = 0; i < 16; i++) lookup("R7 bulk clear", i[3], i[2:0], 13'h0777, 1'b0, 9'h0);
    doWrite(1'b1, 3'd7, 1'b1, 9'h1FF, 1'b0);
    lookup("R7 reload after clear", 1'b1, 3'd7, 13'h1000, 1'b1, 9'h1FF);
  endtask

  task automatic testCollide();
    fillAll();
    doWrite(1'b1, 3'd4, 1'b1, 9'h0AA, 1'b1);
    for (int i = 0; i < 16; i++) begin
      if (i == 12) lookup("R8 written survives", 1'b1, 3'd4, 13'h0042, 1'b1, 9'h0AA);
      else         lookup("R8 others cleared", i[3], i[2:0], 13'h0042, 1'b0, 9'h0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testIdle();
    testBanks();
    testWriteTiming();
    testFull();
    testInvalAll();
    testCollide();
    reqValid = 1'b0;
    testIdle();
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule